// File: doc/BRIEF.md
# Optimal filter energy timing unit

This unit reconstructs calorimeter pulses channel by channel. Each channel delivers five consecutive digitizer samples over a valid/ready stream. While they arrive, the unit removes a per-channel pedestal from each sample and multiplies the result by two sets of per-channel weights. This gives a pulse amplitude (energy) and an amplitude-times-time product. All weights, pedestals and gains sit in a local coefficient store, and the software writes it one 16-bit word at a time.

The energy saturates to a signed 16-bit value and is compared with a programmable threshold. A channel at or below the threshold leaves as a short record that carries only its energy. A channel above the threshold holds the input for a chi-square pass over its five stored residuals. It then leaves as a full record that carries the energy, the 32-bit timing product, the 32-bit quality factor and the channel gain. Records come out in the order the channels arrived. Each record format has its own fixed latency.

The channel count is a parameter: 128 for a normal event and 256 for a staged event.

Top module: `ofc_unit`

## Requirements
- R1: A sample is accepted on a clock edge where `s_valid_i` and `s_ready_o` are both high. The unit groups every five accepted samples into one channel, in order k = 0..4. The channel index is taken from the first of the five beats only, and `s_ch_i` is ignored on the other four.
- R2: Each sample S_k (12-bit unsigned) gives d_k = 16·S_k − P, where P is the 12-bit pedestal code with 4 fractional bits. The a_k weights are signed 16-bit with 12 fractional bits. The energy before saturation is floor(Σ a_k·d_k / 2^16).
- R3: The energy is clamped to the range [−32768, 32767] instead of wrapping.
- R4: A channel gets a full record (`res_full_o` = 1) exactly when its saturated energy is strictly greater than the threshold, with both values treated as signed 16-bit. Otherwise it gets a short record (`res_full_o` = 0).
- R5: The timing field of a full record is floor(Σ b_k·d_k / 2^16), sign-extended to 32 bits. The b_k weights are signed 16-bit.
- R6: The quality field of a full record is Σ floor(r_k² / 2^8), where r_k = d_k − floor(E·g_k / 2^8), E is the saturated energy and g_k is signed 16-bit. The sum saturates at 2^32 − 1.
- R7: A short record has its timing, quality and gain fields at zero. A full record carries the low `GAIN_W` bits of the channel's gain word.
- R8: A write with `cfg_we_i` high stores `cfg_data_i` in the field that `cfg_sel_i` selects for channel `cfg_ch_i`: 0–4 for a_0..a_4, 5–9 for b_0..b_4, 10–14 for g_0..g_4, 15 for the pedestal (low 12 bits), 16 for the gain, and 17 for the threshold, which is shared by all channels and ignores the channel index.
- R9: `res_valid_o` is high for one cycle. For a short record it rises one clock after the edge that accepts the fifth sample. For a full record it rises seven clocks after that edge. `s_ready_o` stays low from that edge until the record is issued.
- R10: Each record's `res_ch_o` is the channel index of its first beat, and records come out in the order the channels were accepted.
- R11: While `rst_ni` is low and after reset, `res_valid_o` is low, `s_ready_o` is high and the threshold is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_valid_i | input | 1 | Sample beat valid |
| s_ready_o | output | 1 | Unit can take a sample beat |
| s_ch_i | input | CH_W | Channel index (sampled on the first beat) |
| s_data_i | input | SAMP_W | Digitizer sample |
| cfg_we_i | input | 1 | Coefficient write strobe |
| cfg_ch_i | input | CH_W | Channel of the coefficient write |
| cfg_sel_i | input | SEL_W | Field select of the coefficient write |
| cfg_data_i | input | COEF_W | Coefficient write data |
| res_valid_o | output | 1 | Result record valid, one cycle |
| res_full_o | output | 1 | 1 = full record, 0 = energy only |
| res_ch_o | output | CH_W | Channel of the record |
| res_gain_o | output | GAIN_W | Channel gain (full records) |
| res_energy_o | output | 16 | Saturated signed energy |
| res_time_o | output | 32 | Signed energy-times-time product |
| res_chi2_o | output | 32 | Saturated quality factor |

## Verification
On every cycle, the assertions check the properties that hold record by record. A short record has zero timing, quality and gain fields. The record format agrees with the energy-to-threshold comparison. The valid pulse lasts one cycle. Input is held off while the chi-square pass runs, and the idle state holds during reset. Only the bench's scenarios can show the arithmetic values: the pedestal-subtracted sums, both kinds of saturation, the exact latencies of the two formats, the use of the first-beat channel index, and the equal / one-below / one-above threshold cases. The bench sweeps every channel of a small configuration through several sample patterns at four thresholds.

// File: rtl/ofc_pkg.sv
`timescale 1ns/1ps
package ofc_pkg;
  localparam int E_W = 16;  // energy field
  localparam int X_W = 32;  // timing and quality fields

  typedef enum logic [1:0] {ST_ACC, ST_FIN, ST_CHI} ofc_state_e;
endpackage

// File: rtl/ofc_coef_store.sv
`timescale 1ns/1ps
module ofc_coef_store #(
  parameter int NUM_CH = 128,
  parameter int NSAMP  = 5,
  parameter int SAMP_W = 12,
  parameter int COEF_W = 16,
  parameter int GAIN_W = 2,
  parameter int CH_W   = 7,
  parameter int SEL_W  = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [CH_W-1:0]          wch_i,
  input  logic [SEL_W-1:0]         wsel_i,
  input  logic [COEF_W-1:0]        wdata_i,
  input  logic [CH_W-1:0]          rch_i,
  output logic signed [COEF_W-1:0] a_o [NSAMP],
  output logic signed [COEF_W-1:0] b_o [NSAMP],
  output logic signed [COEF_W-1:0] g_o [NSAMP],
  output logic [SAMP_W-1:0]        ped_o,
  output logic [GAIN_W-1:0]        gain_o,
  output logic [COEF_W-1:0]        thr_o
);
  localparam int NMEM    = 3*NSAMP + 2;   // per-channel words
  localparam int F_PED   = 3*NSAMP;
  localparam int F_GAIN  = 3*NSAMP + 1;
  localparam int F_THR   = 3*NSAMP + 2;

  logic [COEF_W-1:0] mem_q [NUM_CH][NMEM];
  logic [COEF_W-1:0] thr_q;

  always_ff @(posedge clk_i) begin
    if (we_i && wsel_i < SEL_W'(NMEM)) mem_q[wch_i][wsel_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_q <= '0;
    else if (we_i && wsel_i == SEL_W'(F_THR)) thr_q <= wdata_i;
  end

  for (genvar k = 0; k < NSAMP; k++) begin : g_rd
    assign a_o[k] = mem_q[rch_i][k];
    assign b_o[k] = mem_q[rch_i][NSAMP + k];
    assign g_o[k] = mem_q[rch_i][2*NSAMP + k];
  end

  assign ped_o  = mem_q[rch_i][F_PED][SAMP_W-1:0];
  assign gain_o = mem_q[rch_i][F_GAIN][GAIN_W-1:0];
  assign thr_o  = thr_q;
endmodule

// File: rtl/ofc_mac.sv
`timescale 1ns/1ps
module ofc_mac #(
  parameter int NSAMP    = 5,
  parameter int SAMP_W   = 12,
  parameter int COEF_W   = 16,
  parameter int PED_FRAC = 4,
  parameter int D_W      = 18,
  parameter int ACC_W    = 37,
  parameter int IDX_W    = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     beat_i,
  input  logic                     first_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [SAMP_W-1:0]        samp_i,
  input  logic [SAMP_W-1:0]        ped_i,
  input  logic signed [COEF_W-1:0] a_i,
  input  logic signed [COEF_W-1:0] b_i,
  output logic signed [ACC_W-1:0]  acc_e_o,
  output logic signed [ACC_W-1:0]  acc_t_o,
  output logic signed [D_W-1:0]    d_o [NSAMP]
);
  localparam int P_W = D_W + COEF_W;

  logic signed [D_W-1:0] d;
  logic signed [P_W-1:0] pe, pt;

  // pedestal-subtracted sample, PED_FRAC fractional bits
  assign d  = $signed({{(D_W-SAMP_W-PED_FRAC){1'b0}}, samp_i, {PED_FRAC{1'b0}}})
            - $signed({{(D_W-SAMP_W){1'b0}}, ped_i});
  assign pe = P_W'(d) * P_W'(a_i);
  assign pt = P_W'(d) * P_W'(b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_e_o <= '0;
      acc_t_o <= '0;
      for (int k = 0; k < NSAMP; k++) d_o[k] <= '0;
    end else if (beat_i) begin
      acc_e_o    <= (first_i ? '0 : acc_e_o) + ACC_W'(pe);
      acc_t_o    <= (first_i ? '0 : acc_t_o) + ACC_W'(pt);
      d_o[idx_i] <= d;
    end
  end
endmodule

// File: rtl/ofc_chi2.sv
`timescale 1ns/1ps
module ofc_chi2 #(
  parameter int NSAMP  = 5,
  parameter int COEF_W = 16,
  parameter int D_W    = 18,
  parameter int E_W    = 16,
  parameter int X_W    = 32,
  parameter int EG_SH  = 8,   // coef frac minus pedestal frac
  parameter int SQ_SH  = 8,   // twice pedestal frac
  parameter int IDX_W  = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic signed [E_W-1:0]    e_i,
  input  logic signed [D_W-1:0]    d_i [NSAMP],
  input  logic signed [COEF_W-1:0] g_i [NSAMP],
  output logic                     busy_o,
  output logic                     done_o,
  output logic [X_W-1:0]           chi_o
);
  localparam int EG_W  = E_W + COEF_W;
  localparam int R_W   = EG_W - EG_SH + 2;
  localparam int SQ_W  = 2 * R_W;
  localparam int SUM_W = SQ_W + 1;

  logic [IDX_W-1:0]        cnt_q;
  logic signed [EG_W-1:0]  eg, eg_sh;
  logic signed [R_W-1:0]   r;
  logic signed [SQ_W-1:0]  sq;
  logic [SUM_W-1:0]        sum;
  logic [X_W-1:0]          nxt;

  assign eg    = EG_W'(e_i) * EG_W'(g_i[cnt_q]);
  assign eg_sh = eg >>> EG_SH;
  assign r     = R_W'(d_i[cnt_q]) - R_W'(eg_sh);
  assign sq    = SQ_W'(r) * SQ_W'(r);
  assign sum   = SUM_W'(chi_o) + SUM_W'(sq >> SQ_SH);
  assign nxt   = (sum > SUM_W'({X_W{1'b1}})) ? {X_W{1'b1}} : sum[X_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      chi_o  <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
      busy_o <= 1'b1;
      done_o <= 1'b0;
      chi_o  <= '0;
    end else if (busy_o) begin
      chi_o <= nxt;
      if (cnt_q == IDX_W'(NSAMP-1)) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ofc_unit.sv
`timescale 1ns/1ps
module ofc_unit import ofc_pkg::*; #(
  parameter int NUM_CH    = 128,
  parameter int NSAMP     = 5,
  parameter int SAMP_W    = 12,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 12,
  parameter int PED_FRAC  = 4,
  parameter int GAIN_W    = 2,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int SEL_W    = $clog2(3*NSAMP + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [CH_W-1:0]   s_ch_i,
  input  logic [SAMP_W-1:0] s_data_i,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [COEF_W-1:0] cfg_data_i,
  output logic              res_valid_o,
  output logic              res_full_o,
  output logic [CH_W-1:0]   res_ch_o,
  output logic [GAIN_W-1:0] res_gain_o,
  output logic [15:0]       res_energy_o,
  output logic [31:0]       res_time_o,
  output logic [31:0]       res_chi2_o
);
  localparam int IDX_W = $clog2(NSAMP);
  localparam int D_W   = SAMP_W + PED_FRAC + 2;
  localparam int ACC_W = D_W + COEF_W + $clog2(NSAMP);
  localparam int SH    = COEF_FRAC + PED_FRAC;

  ofc_state_e               st_q;
  logic [IDX_W-1:0]         k_q;
  logic [CH_W-1:0]          ch_q, rch;
  logic signed [COEF_W-1:0] a_arr [NSAMP];
  logic signed [COEF_W-1:0] b_arr [NSAMP];
  logic signed [COEF_W-1:0] g_arr [NSAMP];
  logic [SAMP_W-1:0]        ped_w;
  logic [GAIN_W-1:0]        gain_w;
  logic [COEF_W-1:0]        thr_q;
  logic signed [ACC_W-1:0]  acc_e, acc_t, e_wide, t_wide;
  logic signed [D_W-1:0]    d_arr [NSAMP];
  logic [ACC_W-E_W:0]       e_hi;
  logic [E_W-1:0]           e_sat;
  logic signed [E_W-1:0]    e_q;
  logic [X_W-1:0]           t_q, chi_val;
  logic                     s_acc, above, chi_start, chi_busy, chi_done;

  assign s_ready_o = (st_q == ST_ACC);
  assign s_acc     = s_valid_i && s_ready_o;
  // first beat reads the store at the incoming index
  assign rch       = (st_q == ST_ACC && k_q == '0) ? s_ch_i : ch_q;

  ofc_coef_store #(
    .NUM_CH(NUM_CH), .NSAMP(NSAMP), .SAMP_W(SAMP_W), .COEF_W(COEF_W),
    .GAIN_W(GAIN_W), .CH_W(CH_W), .SEL_W(SEL_W)
  ) u_store (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .wch_i(cfg_ch_i), .wsel_i(cfg_sel_i), .wdata_i(cfg_data_i),
    .rch_i(rch), .a_o(a_arr), .b_o(b_arr), .g_o(g_arr),
    .ped_o(ped_w), .gain_o(gain_w), .thr_o(thr_q)
  );

  ofc_mac #(
    .NSAMP(NSAMP), .SAMP_W(SAMP_W), .COEF_W(COEF_W), .PED_FRAC(PED_FRAC),
    .D_W(D_W), .ACC_W(ACC_W), .IDX_W(IDX_W)
  ) u_mac (
    .clk_i, .rst_ni,
    .beat_i(s_acc), .first_i(k_q == '0), .idx_i(k_q), .samp_i(s_data_i),
    .ped_i(ped_w), .a_i(a_arr[k_q]), .b_i(b_arr[k_q]),
    .acc_e_o(acc_e), .acc_t_o(acc_t), .d_o(d_arr)
  );

  ofc_chi2 #(
    .NSAMP(NSAMP), .COEF_W(COEF_W), .D_W(D_W), .E_W(E_W), .X_W(X_W),
    .EG_SH(COEF_FRAC - PED_FRAC), .SQ_SH(2*PED_FRAC), .IDX_W(IDX_W)
  ) u_chi (
    .clk_i, .rst_ni,
    .start_i(chi_start), .e_i(e_q), .d_i(d_arr), .g_i(g_arr),
    .busy_o(chi_busy), .done_o(chi_done), .chi_o(chi_val)
  );

  assign e_wide = acc_e >>> SH;
  assign t_wide = acc_t >>> SH;
  assign e_hi   = e_wide[ACC_W-1:E_W-1];

  always_comb begin
    if (&e_hi || ~|e_hi) e_sat = e_wide[E_W-1:0];
    else if (e_hi[ACC_W-E_W]) e_sat = {1'b1, {(E_W-1){1'b0}}};
    else e_sat = {1'b0, {(E_W-1){1'b1}}};
  end

  assign above     = $signed(e_sat) > $signed(thr_q);
  assign chi_start = (st_q == ST_FIN) && above;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_ACC;
      k_q <= '0;
      ch_q <= '0;
      e_q <= '0;
      t_q <= '0;
      res_valid_o <= 1'b0;
      res_full_o <= 1'b0;
      res_ch_o <= '0;
      res_gain_o <= '0;
      res_energy_o <= '0;
      res_time_o <= '0;
      res_chi2_o <= '0;
    end else begin
      res_valid_o <= 1'b0;
      unique case (st_q)
        ST_ACC: if (s_acc) begin
          if (k_q == '0) ch_q <= s_ch_i;
          if (k_q == IDX_W'(NSAMP-1)) begin
            k_q <= '0;
            st_q <= ST_FIN;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        ST_FIN: begin
          e_q <= $signed(e_sat);
          t_q <= X_W'(t_wide);
          if (above) begin
            st_q <= ST_CHI;
          end else begin
            res_valid_o <= 1'b1;
            res_full_o <= 1'b0;
            res_ch_o <= ch_q;
            res_energy_o <= e_sat;
            res_time_o <= '0;
            res_chi2_o <= '0;
            res_gain_o <= '0;
            st_q <= ST_ACC;
          end
        end
        ST_CHI: if (chi_done) begin
          res_valid_o <= 1'b1;
          res_full_o <= 1'b1;
          res_ch_o <= ch_q;
          res_energy_o <= e_q;
          res_time_o <= t_q;
          res_chi2_o <= chi_val;
          res_gain_o <= gain_w;
          st_q <= ST_ACC;
        end
        default: st_q <= ST_ACC;
      endcase
    end
  end
endmodule

// File: rtl/ofc_unit_chk.sv
`timescale 1ns/1ps
module ofc_unit_chk #(
  parameter int GAIN_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_ready_o,
  input logic              res_valid_o,
  input logic              res_full_o,
  input logic [GAIN_W-1:0] res_gain_o,
  input logic [15:0]       res_energy_o,
  input logic [31:0]       res_time_o,
  input logic [31:0]       res_chi2_o,
  input logic [15:0]       thr_i,
  input logic              chi_busy_i
);
  a_r11_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> !res_valid_o && s_ready_o);

  a_r7_short_fields_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_full_o |-> res_time_o == '0 && res_chi2_o == '0 && res_gain_o == '0);

  a_r4_full_above_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_full_o |-> $signed(res_energy_o) > $signed(thr_i));

  a_r4_short_not_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_full_o |-> $signed(res_energy_o) <= $signed(thr_i));

  a_r9_stall_in_chi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chi_busy_i |-> !s_ready_o);

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  a_r9_full_after_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_full_o |-> $past(!s_ready_o));
endmodule

bind ofc_unit ofc_unit_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .s_ready_o(s_ready_o),
  .res_valid_o(res_valid_o), .res_full_o(res_full_o), .res_gain_o(res_gain_o),
  .res_energy_o(res_energy_o), .res_time_o(res_time_o), .res_chi2_o(res_chi2_o),
  .thr_i(thr_q), .chi_busy_i(chi_busy)
);

// File: tb/tb_ofc_unit.sv
`timescale 1ns/1ps
module tb_ofc_unit;
  localparam int NCH = 8;
  localparam int NS = 5;
  localparam int SEL_THR = 3*NS + 2;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, cfg_we = 0;
  logic [2:0] s_ch = 0, cfg_ch = 0;
  logic [11:0] s_data = 0;
  logic [4:0] cfg_sel = 0;
  logic [15:0] cfg_data = 0;
  logic s_ready_o, res_valid_o, res_full_o;
  logic [2:0] res_ch_o;
  logic [1:0] res_gain_o;
  logic [15:0] res_energy_o;
  logic [31:0] res_time_o, res_chi2_o;

  always #2 clk = ~clk;

  ofc_unit #(.NUM_CH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .s_valid_i(s_valid), .s_ready_o(s_ready_o),
    .s_ch_i(s_ch), .s_data_i(s_data), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data), .res_valid_o(res_valid_o),
    .res_full_o(res_full_o), .res_ch_o(res_ch_o), .res_gain_o(res_gain_o),
    .res_energy_o(res_energy_o), .res_time_o(res_time_o), .res_chi2_o(res_chi2_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit fin = 0;
  int a_c [NCH][NS], b_c [NCH][NS], g_c [NCH][NS];
  int ped_c [NCH], gain_c [NCH];
  int thr_v = 0;

  int exp_ch [512], exp_e [512], exp_gain [512], acc_cyc [512];
  bit exp_full [512];
  longint exp_t [512], exp_x [512];
  string exp_tag [512];
  int n_exp = 0, n_rx = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic model(input int c, input int s [NS], output int e, output bit full,
                       output longint t, output longint x, output bit sat);
    longint se = 0, st = 0, er;
    longint d [NS];
    for (int k = 0; k < NS; k++) begin
      d[k] = longint'(s[k]) * 16 - ped_c[c];
      se += a_c[c][k] * d[k];
      st += b_c[c][k] * d[k];
    end
    er = se >>> 16;
    sat = (er > 32767) || (er < -32768);
    e = (er > 32767) ? 32767 : (er < -32768) ? -32768 : int'(er);
    full = e > thr_v;
    t = st >>> 16;
    x = 0;
    for (int k = 0; k < NS; k++) begin
      longint r;
      r = d[k] - ((longint'(e) * g_c[c][k]) >>> 8);
      x += (r * r) >>> 8;
      if (x > 64'd4294967295) x = 64'd4294967295;
    end
  endtask

  task automatic cfg_write(input int c, input int sel, input int v);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 3'(c); cfg_sel = 5'(sel); cfg_data = 16'(v);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_thr(input int v);
    cfg_write(0, SEL_THR, v);  // R8: field 17, shared
    thr_v = v;
  endtask

  function automatic int samp(input int c, input int p, input int k);
    if (p == 0) return 0;
    return (p * 613 + k * (211 + c * 17) + 50) % 4096;
  endfunction

  task automatic send_ch(input int c, input int p);
    int s [NS];
    int e, idx;
    bit full, sat;
    longint t, x;
    for (int k = 0; k < NS; k++) s[k] = samp(c, p, k);
    model(c, s, e, full, t, x, sat);
    idx = n_exp;
    exp_ch[idx] = c; exp_e[idx] = e; exp_full[idx] = full;
    exp_t[idx] = t; exp_x[idx] = x; exp_gain[idx] = gain_c[c];
    exp_tag[idx] = sat ? "R3" : "R2";
    n_exp++;
    for (int k = 0; k < NS; k++) begin
      @(negedge clk);
      s_valid = 1;
      s_ch = (k == 0) ? 3'(c) : 3'(c ^ 1);  // R1: later beats carry a wrong index
      s_data = 12'(s[k]);
      while (!s_ready_o) @(negedge clk);
      @(posedge clk);
      #1;
      if (k == NS - 1) acc_cyc[idx] = cyc;
    end
    @(negedge clk);
    s_valid = 0;
    chk(!s_ready_o, "R9", "ready after fifth sample", longint'(s_ready_o), 0);
  endtask

  task automatic drain();
    @(negedge clk);
    s_valid = 0;
    while (n_rx != n_exp) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid_o) begin
      int i;
      i = n_rx;
      chk(int'(res_ch_o) == exp_ch[i], "R1 R10", "channel", res_ch_o, exp_ch[i]);
      chk(res_full_o == exp_full[i], "R4", "full flag", res_full_o, exp_full[i]);
      chk(int'($signed(res_energy_o)) == exp_e[i], exp_tag[i], "energy",
          $signed(res_energy_o), exp_e[i]);
      if (exp_full[i]) begin
        chk(longint'($signed(res_time_o)) == exp_t[i], "R5", "timing",
            $signed(res_time_o), exp_t[i]);
        chk(longint'(res_chi2_o) == exp_x[i], "R6", "chi2", res_chi2_o, exp_x[i]);
        chk(int'(res_gain_o) == exp_gain[i], "R8", "gain", res_gain_o, exp_gain[i]);
        chk(cyc - acc_cyc[i] == 7, "R9", "full latency", cyc - acc_cyc[i], 7);
      end else begin
        chk(res_time_o == 0 && res_chi2_o == 0 && res_gain_o == 0, "R7",
            "short record fields", longint'(res_time_o) + res_chi2_o + res_gain_o, 0);
        chk(cyc - acc_cyc[i] == 1, "R9", "short latency", cyc - acc_cyc[i], 1);
      end
      n_rx++;
    end
  end

  initial begin
    #400000;
    if (!fin) begin
      n_err++;
      $display("FAIL watchdog: actual %0d records expected %0d", n_rx, n_exp);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int thr_list [4] = '{32767, 0, 2000, -32768};
    repeat (3) @(negedge clk);
    chk(!res_valid_o && s_ready_o, "R11", "idle during reset",
        longint'({res_valid_o, s_ready_o}), 1);
    rst_n = 1;
    @(negedge clk);
    chk(!res_valid_o && s_ready_o, "R11", "idle after reset",
        longint'({res_valid_o, s_ready_o}), 1);

    for (int c = 0; c < NCH; c++) begin
      ped_c[c] = 100 + 37 * c;
      gain_c[c] = c % 4;
      for (int k = 0; k < NS; k++) begin
        a_c[c][k] = 1000 + 300 * k - 97 * c;
        b_c[c][k] = 500 * k - 1000 + 13 * c;
        g_c[c][k] = 4096 - 600 * (k > 2 ? k - 2 : 2 - k) + 11 * c;
        if (c == 6) begin a_c[c][k] = 32767; g_c[c][k] = -32768; end
        if (c == 7) a_c[c][k] = -32768;
        cfg_write(c, k, a_c[c][k]);
        cfg_write(c, NS + k, b_c[c][k]);
        cfg_write(c, 2 * NS + k, g_c[c][k]);
      end
      cfg_write(c, 3 * NS, ped_c[c]);
      cfg_write(c, 3 * NS + 1, gain_c[c]);
    end

    // R11: threshold resets to zero, so an all-zero-sample channel with
    // negative energy gives a short record before any threshold write
    send_ch(1, 0);
    drain();

    foreach (thr_list[ti]) begin
      set_thr(thr_list[ti]);
      for (int p = 0; p < 5; p++)
        for (int c = 0; c < NCH; c++) send_ch(c, p);
      drain();
    end

    // R4: equal, one below, one above
    begin
      int s [NS];
      int e;
      bit full, sat;
      longint t, x;
      for (int k = 0; k < NS; k++) s[k] = samp(1, 3, k);
      model(1, s, e, full, t, x, sat);
      set_thr(e);     send_ch(1, 3); drain();
      set_thr(e - 1); send_ch(1, 3); drain();
      set_thr(e + 1); send_ch(1, 3); drain();
    end

    chk(n_rx == n_exp, "R10", "record count", n_rx, n_exp);
    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule